// File: doc/BRIEF.md
# Edge-Selectable Multi-Input Wakeup Unit

This block watches an 8-bit input port and latches a pending flag for each pin when that pin shows the edge chosen for it. Each pin has its own polarity bit: 0 selects a low-to-high edge and 1 selects a high-to-low edge. The pins are assumed to arrive already conditioned by input hysteresis. Each pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized sample with the sample from one cycle earlier.

Three 8-bit registers hold the state: an arm mask, a polarity mask and the pending flags. Software changes any one of them through a single write port. The port can load a whole value, set the bits selected by a mask, or clear the bits selected by a mask. The wakeup request is the OR over all pins of (pending AND armed). It comes straight from the registers, so no clock is needed between a register change and the request.

Changing a polarity bit never primes the detector again. The new polarity applies from the next synchronized sample. To reconfigure a pin, software disarms it, writes the new polarity, clears its pending flag and then arms it again.

Top module: `pin_wakeup_unit`

## Requirements
- R1: While reset is low, the arm, polarity and pending registers and the wake output are all zero. The synchronizer and the detector also start from a low sample.
- R2: `wr_sel` picks the register: 0 = arm, 1 = polarity, 2 = pending, 3 = none. `wr_op` picks the action: 0 loads `wr_data`, 1 sets the bits where `wr_data` is 1, 2 clears the bits where `wr_data` is 1, 3 leaves the register unchanged. A write takes effect at the clock edge where `wr_en` is high. Registers that are not selected keep their value.
- R3: A pin with polarity bit 0 that goes from low to high sets its pending bit at the third rising clock edge after the pin changes.
- R4: A pin with polarity bit 1 that goes from high to low sets its pending bit at the third rising clock edge after the pin changes.
- R5: The edge opposite to a pin's selected polarity does not set its pending bit.
- R6: A detected edge sets the pending bit whether or not the pin is armed.
- R7: When a detected edge and a software clear or load of the same pending bit meet at the same clock edge, the bit ends up set.
- R8: `wake_o` is high exactly when some bit is both pending and armed. It follows register changes without an added cycle.
- R9: A pending bit stays set until software clears it or loads a 0 into it.
- R10: Changing a polarity bit while the pin is steady sets no pending bit. After the reconfiguration sequence (disarm, new polarity, clear pending, re-arm), an edge of the new polarity sets the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Conditioned port inputs, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 arm, 1 polarity, 2 pending, 3 none |
| wr_op | input | 2 | Action: 0 load, 1 set mask, 2 clear mask, 3 hold |
| wr_data | input | 8 | Load value or bit mask |
| arm_o | output | 8 | Arm register |
| pol_o | output | 8 | Polarity register (0 rising, 1 falling) |
| pend_o | output | 8 | Pending flags |
| wake_o | output | 1 | Combined wakeup / interrupt request |

## Verification
The assertions assume that the pin inputs are low while reset is asserted. A pin that is high through reset would look like a rising edge on release. They also assume the write fields are stable around the clock edge. The bench holds every pin low during reset and changes pins and write fields only on the falling clock edge. Its random phase changes the pins only every few cycles, so that each change passes cleanly through the synchronizer. It mixes in writes that land in the same cycle as edges, which exercises the rule that an edge wins over a clear.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    SEL_ARM  = 2'd0,
    SEL_POL  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } wake_sel_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_HOLD  = 2'd3
  } wake_op_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] smp_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;

  function automatic logic [WIDTH-1:0] edge_hits(
    input logic [WIDTH-1:0] prev,
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] pol
  );
    return (~prev & cur & ~pol) | (prev & ~cur & pol);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= smp_i;
  end

  assign hit_o = edge_hits(prev_q, smp_i, pol_i);

  // R5: a hit on a bit means its new sample is the level the polarity asks for
  a_r5_hit_level: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~(smp_i ^ pol_i)) == '0);
  // R10: a steady sample yields no hit even when polarity changed
  a_r10_steady_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_i == $past(smp_i)) |-> (hit_o == '0));
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  wake_sel_e        wr_sel,
  input  wake_op_e         wr_op,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] hit_i,
  output logic [WIDTH-1:0] arm_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] pend_q
);
  function automatic logic [WIDTH-1:0] apply_op(
    input logic [WIDTH-1:0] cur,
    input wake_op_e         op,
    input logic [WIDTH-1:0] data
  );
    case (op)
      OP_LOAD:  return data;
      OP_SET:   return cur | data;
      OP_CLEAR: return cur & ~data;
      default:  return cur;
    endcase
  endfunction

  logic wr_arm, wr_pol, wr_pend;
  logic [WIDTH-1:0] pend_sw;

  assign wr_arm  = wr_en && (wr_sel == SEL_ARM);
  assign wr_pol  = wr_en && (wr_sel == SEL_POL);
  assign wr_pend = wr_en && (wr_sel == SEL_PEND);
  assign pend_sw = wr_pend ? apply_op(pend_q, wr_op, wr_data) : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      pol_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_arm) arm_q <= apply_op(arm_q, wr_op, wr_data);
      if (wr_pol) pol_q <= apply_op(pol_q, wr_op, wr_data);
      pend_q <= pend_sw | hit_i;
    end
  end

  // R1: registers are clear during reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (arm_q == '0 && pol_q == '0 && pend_q == '0));
  // R2: unselected configuration registers hold
  a_r2_arm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_arm |=> $stable(arm_q));
  a_r2_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pol |=> $stable(pol_q));
  // R7: an edge always lands in the pending register
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));
  // R9: without a software write the pending bits never drop
  a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> (($past(pend_q) & ~pend_q) == '0));
  // R5: without a software write, new pending bits come only from hits
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q & ~$past(pend_q) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/pin_wakeup_unit.sv
module pin_wakeup_unit
  import wake_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [1:0]       wr_op,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] arm_o,
  output logic [WIDTH-1:0] pol_o,
  output logic [WIDTH-1:0] pend_o,
  output logic             wake_o
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] armed_pending;

  wake_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
  );

  wake_edge_det #(.WIDTH(WIDTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .smp_i(pin_sync), .pol_i(pol_o), .hit_o(edge_hit)
  );

  wake_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_sel(wake_sel_e'(wr_sel)), .wr_op(wake_op_e'(wr_op)),
    .wr_data(wr_data), .hit_i(edge_hit),
    .arm_q(arm_o), .pol_q(pol_o), .pend_q(pend_o)
  );

  assign armed_pending = pend_o & arm_o;
  assign wake_o        = |armed_pending;

  // R8: a request needs at least one armed bit and one pending bit
  a_r8_wake_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (arm_o != '0 && pend_o != '0));
  // R8: nothing pending means no request
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |-> !wake_o);
endmodule

// File: tb/pin_wakeup_unit_bench.sv
module pin_wakeup_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] pin_i = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [1:0] wr_op = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] arm_o, pol_o, pend_o;
  logic       wake_o;

  int checks = 0;
  int fails  = 0;
  bit compare_on = 1'b0;

  always #10 clk = ~clk;

  pin_wakeup_unit u_pin_wakeup_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_op(wr_op), .wr_data(wr_data), .arm_o(arm_o), .pol_o(pol_o),
    .pend_o(pend_o), .wake_o(wake_o)
  );

  // reference model state
  logic [7:0] m_s1, m_s2, m_old, m_arm, m_pol, m_pend;

  function automatic logic [7:0] m_hits(logic [7:0] old, logic [7:0] now, logic [7:0] pol);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (old[i] != now[i]) r[i] = (now[i] == ~pol[i]);
    return r;
  endfunction

  function automatic logic [7:0] m_apply(logic [7:0] cur, logic [1:0] op, logic [7:0] d);
    if (op == 2'd0) return d;
    if (op == 2'd1) return cur | d;
    if (op == 2'd2) return cur & ~d;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_old = '0; m_arm = '0; m_pol = '0; m_pend = '0;
    end else begin
      logic [7:0] h, np;
      h  = m_hits(m_old, m_s2, m_pol);
      np = (wr_en && wr_sel == 2'd2) ? m_apply(m_pend, wr_op, wr_data) : m_pend;
      m_pend = np | h;
      if (wr_en && wr_sel == 2'd0) m_arm = m_apply(m_arm, wr_op, wr_data);
      if (wr_en && wr_sel == 2'd1) m_pol = m_apply(m_pol, wr_op, wr_data);
      m_old = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_op(logic [1:0] sel, logic [1:0] op, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_op = op; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk("R3/R4 pend random", pend_o, m_pend);
      chk("R2 arm random", arm_o, m_arm);
      chk("R2 pol random", pol_o, m_pol);
      chk("R8 wake random", {7'd0, wake_o}, {7'd0, |(m_pend & m_arm)});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 arm in reset", arm_o, 8'h00);
    chk("R1 pend in reset", pend_o, 8'h00);
    chk("R1 wake in reset", {7'd0, wake_o}, 8'h00);
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1 pol after reset", pol_o, 8'h00);

    // R2 register operations
    do_op(2'd0, 2'd0, 8'hA5); chk("R2 load arm", arm_o, 8'hA5);
    do_op(2'd0, 2'd1, 8'h0A); chk("R2 set arm", arm_o, 8'hAF);
    do_op(2'd0, 2'd2, 8'h21); chk("R2 clear arm", arm_o, 8'h8E);
    do_op(2'd0, 2'd3, 8'hFF); chk("R2 hold arm", arm_o, 8'h8E);
    do_op(2'd3, 2'd0, 8'h00); chk("R2 sel none arm", arm_o, 8'h8E);
    chk("R2 sel none pend", pend_o, 8'h00);
    do_op(2'd1, 2'd0, 8'h3C); chk("R2 load pol", pol_o, 8'h3C);
    chk("R2 arm untouched by pol write", arm_o, 8'h8E);
    do_op(2'd1, 2'd0, 8'h00); chk("R2 reload pol", pol_o, 8'h00);

    // R3 rising edge latency, R6 unarmed pin, R8 request
    pin_i = 8'h01;
    step(2); chk("R3 not yet pending", pend_o, 8'h00);
    step(1); chk("R3 rising sets pend", pend_o, 8'h01);
    chk("R6 unarmed pin no wake", {7'd0, wake_o}, 8'h00);
    step(4); chk("R9 pend sticky", pend_o, 8'h01);
    do_op(2'd0, 2'd1, 8'h01); chk("R8 wake after arm", {7'd0, wake_o}, 8'h01);

    // R5 opposite edge ignored, R9 software clear
    pin_i = 8'h00;
    step(4); chk("R5 falling ignored on rising pin", pend_o, 8'h01);
    do_op(2'd2, 2'd2, 8'h01); chk("R9 clear pend", pend_o, 8'h00);
    chk("R8 wake drops", {7'd0, wake_o}, 8'h00);

    // R10 polarity change on a steady pin
    do_op(2'd1, 2'd1, 8'h03);
    step(4); chk("R10 pol change no pend", pend_o, 8'h00);
    pin_i = 8'h02;
    step(4); chk("R5 rising ignored on falling pin", pend_o, 8'h00);
    pin_i = 8'h00;
    step(2); chk("R4 not yet pending", pend_o, 8'h00);
    step(1); chk("R4 falling sets pend", pend_o, 8'h02);
    chk("R8 wake on armed bit1", {7'd0, wake_o}, 8'h01);

    // R10 reconfiguration sequence on bit 1
    do_op(2'd0, 2'd2, 8'h02);
    do_op(2'd1, 2'd2, 8'h02);
    do_op(2'd2, 2'd2, 8'h02);
    do_op(2'd0, 2'd1, 8'h02);
    chk("R10 pend clean after sequence", pend_o, 8'h00);
    chk("R10 pol after sequence", pol_o, 8'h01);
    pin_i = 8'h02;
    step(3); chk("R10 new polarity active", pend_o, 8'h02);

    // R7 edge beats a same-cycle clear
    pin_i = 8'h06;
    step(2);
    do_op(2'd2, 2'd2, 8'h06);
    chk("R7 edge wins over clear", pend_o, 8'h04);
    do_op(2'd2, 2'd0, 8'h00);
    pin_i = 8'h00;
    step(4); chk("R5 falls ignored, pend empty", pend_o, 8'h00);

    // constrained random phase against the model
    compare_on = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      if (c % 4 == 0) pin_i = pin_i ^ 8'($urandom_range(0, 255) & $urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom_range(0, 3));
        wr_op = 2'($urandom_range(0, 3));
        wr_data = 8'($urandom_range(0, 255));
      end else wr_en = 1'b0;
      step(1);
    end
    wr_en = 1'b0;
    step(1);
    compare_on = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule